// File: doc/BRIEF.md
# Parity-Aligned Three-Lane Frame Deserializer

This block sits behind three single-ended serial data lanes and runs on the bit clock that arrives alongside them. The stream carries four 8-bit channel samples per frame, each sample protected by an odd-parity bit. The stream has no sync word and no frame marker, so the block finds the frame phase by itself. It keeps the most recent frame's worth of bits from every lane. At each candidate frame end it rebuilds the four 9-bit words and tests their parity.

While hunting, every failed test moves the candidate boundary one bit later. Four consecutive frames that pass all four parity tests at one phase put the block in lock. While in lock it emits the four samples once per frame with a one-cycle strobe, flags parity failures per channel, and counts failing frames. Three failing frames in a row drop lock, and the hunt starts again.

Top module: `parity_frame_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its state. After that edge `locked`, `sample_valid`, `samples`, `parity_error` and `err_frames` are all zero.
- R2: A frame is 12 bit periods long, numbered slot 0 to slot 11.
  - Lane 0 carries channel 0 bits 0..7 in slots 0..7 and that channel's parity bit in slot 8. Lanes 1 and 2 do the same for channels 1 and 2.
  - Channel 3 rides in slots 9..11: bits 0,1,2 on lane 0, bits 3,4,5 on lane 1, and bits 6,7 followed by its parity bit on lane 2.
  - `samples[8*i+7:8*i]` holds channel i.
- R3: A 9-bit word passes when its count of ones, parity bit included, is odd. `parity_error[i]` is 1 when word i fails.
- R4: While not locked, a frame end at which any word fails makes the very next bit the next candidate frame end, so the phase advances by one slot, modulo 12. A frame end at which all four words pass keeps the phase, and the next test comes 12 bits later.
- R5: `locked` rises in the cycle after the edge that completes the fourth consecutive all-pass frame at one phase.
- R6: While locked, a failing frame extends a run of failures, and a passing frame clears that run. When the run reaches 3, `locked` falls in the cycle after that frame. The hunt then resumes as in R4, starting one slot later.
- R7: Each frame end evaluated while `locked` is high produces a one-cycle `sample_valid` pulse, failing frames included. `samples` and `parity_error` update only with that pulse and hold otherwise.
- R8: `err_frames` adds one for each failing frame evaluated while locked and saturates at all ones, `ERR_W` bits wide (default 16).
- R9: `sample_valid` is high in the cycle that follows the clock edge that captures the slot 11 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_in | input | 3 | Serial data lanes, bit 0 = lane 0 |
| locked | output | 1 | Frame phase is locked |
| sample_valid | output | 1 | One-cycle strobe per locked frame |
| samples | output | 32 | Four 8-bit channel samples, channel 0 in the low byte |
| parity_error | output | 4 | Per-channel parity failure of the last emitted frame |
| err_frames | output | ERR_W | Saturating count of failing frames seen while locked |

## Verification
A wrong bit counter or a wrong slip decision shifts the sample phase. The first strobe that follows then carries scrambled samples and false parity flags, and lock is late or missing. A damaged pass or fail run counter shows as `locked` changing one frame too early or too late, at most 12 cycles after the frame that should have decided it. A wrong slot mapping shows at once on the first strobe after lock, as bytes that differ from the transmitted data. Every output is compared with a reference model on every cycle, so the first differing cycle is reported.

// File: rtl/pfa_pkg.sv
// Package: shared parameters and types for the parity frame aligner.
// Assumes the channel words split evenly over the lanes for the last channel.
package pfa_pkg;

    // Lock controller states.
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;

    // Bits per frame: one full word per lane plus the shared last word.
    function automatic int frame_bits(input int lanes, input int word_w);
        return (word_w + 1) + (word_w + 1) / lanes;
    endfunction

endpackage

// File: rtl/pfa_lane_window.sv
// Module: sliding window over one serial lane.
// Holds the previous FRAME_BITS-1 bits and appends the live input, so that the
// window presents a whole frame in the cycle the last bit arrives. Slot k of
// the frame is at index k of 'slots' (slot 0 = oldest bit).
module pfa_lane_window #(
    parameter int FRAME_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  din,
    output logic [FRAME_BITS-1:0] slots
);

    logic [FRAME_BITS-2:0] hist_q;
    logic [FRAME_BITS-1:0] win;

    // Shift history: newest bit enters at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[FRAME_BITS-3:0], din};
    end

    // Present the window with the oldest bit at the top.
    assign win = {hist_q, din};

    // Reverse so that index equals slot number.
    for (genvar k = 0; k < FRAME_BITS; k++) begin : g_slot
        assign slots[k] = win[FRAME_BITS-1-k];
    end

endmodule

// File: rtl/pfa_word_unpack.sv
// Module: rebuilds the channel words from the lane windows and tests parity.
// Assumes the frame slot layout: each lane first carries its own channel word
// and parity, then the last channel is spread SPLIT bits per lane in lane order.
module pfa_word_unpack #(
    parameter int LANES      = 3,
    parameter int WORD_W     = 8,
    parameter int FRAME_BITS = 12
) (
    input  logic [LANES-1:0][FRAME_BITS-1:0] slots,
    output logic [LANES:0][WORD_W-1:0]       data,
    output logic [LANES:0]                   perr
);

    localparam int SPLIT = (WORD_W + 1) / LANES;

    logic [LANES:0] par;

    // Channels carried whole on their own lane.
    for (genvar ch = 0; ch < LANES; ch++) begin : g_direct
        assign data[ch] = slots[ch][WORD_W-1:0];
        assign par[ch]  = slots[ch][WORD_W];
    end

    // Last channel, spread across the lanes in the tail slots.
    for (genvar j = 0; j <= WORD_W; j++) begin : g_split
        localparam int LN = j / SPLIT;
        localparam int SL = WORD_W + 1 + (j % SPLIT);
        if (j < WORD_W) begin : g_bit
            assign data[LANES][j] = slots[LN][SL];
        end else begin : g_par
            assign par[LANES] = slots[LN][SL];
        end
    end

    // Odd parity: an even count of ones flags an error.
    for (genvar ch = 0; ch <= LANES; ch++) begin : g_chk
        assign perr[ch] = ~(^{par[ch], data[ch]});
    end

endmodule

// File: rtl/pfa_lock_ctrl.sv
// Module: hunt and lock controller.
// Counts consecutive passing frames while hunting and consecutive failing
// frames while locked. Asks for a one-bit slip when the current phase is
// rejected. Assumes 'boundary' is high for one cycle per candidate frame end.
module pfa_lock_ctrl #(
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic boundary,
    input  logic frame_ok,
    output logic locked,
    output logic slip
);
    import pfa_pkg::*;

    localparam int GW = $clog2(LOCK_FRAMES + 1);
    localparam int BW = $clog2(UNLOCK_FRAMES + 1);

    lock_state_t     state_q;
    logic [GW-1:0]   good_q;
    logic [BW-1:0]   bad_q;
    logic            lose_now;
    logic            gain_now;

    // Decisions taken at this frame end.
    assign gain_now = boundary && (state_q == ST_HUNT) && frame_ok
                      && (good_q == GW'(LOCK_FRAMES - 1));
    assign lose_now = boundary && (state_q == ST_LOCKED) && !frame_ok
                      && (bad_q == BW'(UNLOCK_FRAMES - 1));
    assign slip     = boundary && !frame_ok && ((state_q == ST_HUNT) || lose_now);
    assign locked   = (state_q == ST_LOCKED);

    // State and run counters update at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
            bad_q   <= '0;
        end else if (boundary) begin
            if (gain_now) begin
                state_q <= ST_LOCKED;
                good_q  <= '0;
                bad_q   <= '0;
            end else if (lose_now) begin
                state_q <= ST_HUNT;
                good_q  <= '0;
                bad_q   <= '0;
            end else if (state_q == ST_HUNT) begin
                good_q  <= frame_ok ? good_q + 1'b1 : '0;
            end else begin
                bad_q   <= frame_ok ? '0 : bad_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/parity_frame_aligner.sv
// Module: top of the parity-aligned frame deserializer.
// Runs on the forwarded bit clock; one lane bit per cycle. Finds the frame
// phase from odd parity alone, then emits samples once per frame while locked.
// Assumes lanes are already synchronous to clk.
module parity_frame_aligner #(
    parameter int LANES         = 3,
    parameter int WORD_W        = 8,
    parameter int LOCK_FRAMES   = 4,
    parameter int UNLOCK_FRAMES = 3,
    parameter int ERR_W         = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              lane_in,
    output logic                          locked,
    output logic                          sample_valid,
    output logic [(LANES+1)*WORD_W-1:0]   samples,
    output logic [LANES:0]                parity_error,
    output logic [ERR_W-1:0]              err_frames
);
    localparam int CHANNELS   = LANES + 1;
    localparam int FRAME_BITS = pfa_pkg::frame_bits(LANES, WORD_W);
    localparam int CW         = $clog2(FRAME_BITS);
    localparam logic [CW-1:0]    LAST_SLOT = CW'(FRAME_BITS - 1);
    localparam logic [ERR_W-1:0] ERR_MAX   = '1;

    logic [LANES-1:0][FRAME_BITS-1:0] slots;
    logic [CHANNELS-1:0][WORD_W-1:0]  data;
    logic [CHANNELS-1:0]              perr;
    logic [CW-1:0]                    bit_q;
    logic                             boundary;
    logic                             frame_ok;
    logic                             slip;

    // One window per lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        pfa_lane_window #(.FRAME_BITS(FRAME_BITS)) i_win (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (lane_in[l]),
            .slots (slots[l])
        );
    end

    pfa_word_unpack #(
        .LANES(LANES), .WORD_W(WORD_W), .FRAME_BITS(FRAME_BITS)
    ) i_unpack (
        .slots (slots),
        .data  (data),
        .perr  (perr)
    );

    assign boundary = (bit_q == LAST_SLOT);
    assign frame_ok = ~|perr;

    pfa_lock_ctrl #(
        .LOCK_FRAMES(LOCK_FRAMES), .UNLOCK_FRAMES(UNLOCK_FRAMES)
    ) i_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .boundary (boundary),
        .frame_ok (frame_ok),
        .locked   (locked),
        .slip     (slip)
    );

    // Bit position counter; a slip holds it on the last slot for one more bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_q <= '0;
        else if (boundary) bit_q <= slip ? LAST_SLOT : '0;
        else               bit_q <= bit_q + 1'b1;
    end

    // Sample output registers and strobe, active only while locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_valid <= 1'b0;
            samples      <= '0;
            parity_error <= '0;
        end else begin
            sample_valid <= boundary && locked;
            if (boundary && locked) begin
                samples      <= data;
                parity_error <= perr;
            end
        end
    end

    // Saturating count of failing frames seen while locked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_frames <= '0;
        else if (boundary && locked && !frame_ok && err_frames != ERR_MAX)
            err_frames <= err_frames + 1'b1;
    end

endmodule

// File: rtl/pfa_checker.sv
// Module: port-level properties of the parity frame aligner, bound to the top.
module pfa_checker #(
    parameter int CHANNELS = 4,
    parameter int WORD_W   = 8,
    parameter int ERR_W    = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         locked,
    input logic                         sample_valid,
    input logic [CHANNELS*WORD_W-1:0]   samples,
    input logic [CHANNELS-1:0]          parity_error,
    input logic [ERR_W-1:0]             err_frames
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    // R7: a strobe only follows a frame end seen while locked.
    assert_valid_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> $past(locked));

    // R7: the strobe lasts one cycle.
    assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R7: outputs hold between strobes.
    assert_samples_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> (samples == $past(samples) && parity_error == $past(parity_error)));

    // R5: lock cannot rise together with a strobe.
    assert_lock_rise_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> !sample_valid);

    // R6: lock only falls on a failing emitted frame.
    assert_lock_fall_on_error_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> (sample_valid && (|parity_error)));

    // R8: the counter moves only by one, and only on a failing strobe.
    assert_err_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frames != $past(err_frames)) |->
            (err_frames == ERR_W'($past(err_frames) + 1'b1) && sample_valid && (|parity_error)));

    // R8: a failing strobe below saturation increments the counter.
    assert_err_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && (|parity_error) && $past(err_frames) != ERR_MAX) |->
            err_frames == ERR_W'($past(err_frames) + 1'b1));

    // R8: saturation holds.
    assert_err_saturates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err_frames) == ERR_MAX) |-> (err_frames == ERR_MAX));

endmodule

bind parity_frame_aligner pfa_checker #(
    .CHANNELS(CHANNELS), .WORD_W(WORD_W), .ERR_W(ERR_W)
) i_pfa_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .locked       (locked),
    .sample_valid (sample_valid),
    .samples      (samples),
    .parity_error (parity_error),
    .err_frames   (err_frames)
);

// File: tb/test_parity_frame_aligner.sv
module test_parity_frame_aligner;
    localparam int CLK_PERIOD = 10;
    localparam int ERR_W      = 4;
    localparam int ERR_MAX    = (1 << ERR_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        lane_in = '0;
    logic              locked;
    logic              sample_valid;
    logic [31:0]       samples;
    logic [3:0]        parity_error;
    logic [ERR_W-1:0]  err_frames;

    int  checks = 0;
    int  failures = 0;
    bit  done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    parity_frame_aligner #(.ERR_W(ERR_W)) i_parity_frame_aligner (
        .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .locked(locked),
        .sample_valid(sample_valid), .samples(samples),
        .parity_error(parity_error), .err_frames(err_frames)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit qa[$], qb[$], qc[$];
    int m_cnt, m_good, m_bad;
    bit m_locked;
    bit e_valid;
    logic [31:0] e_samp;
    logic [3:0]  e_perr;
    int e_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            qa.delete(); qb.delete(); qc.delete();
            for (int i = 0; i < 12; i++) begin qa.push_back(0); qb.push_back(0); qc.push_back(0); end
            m_cnt = 0; m_good = 0; m_bad = 0; m_locked = 0;
            e_valid = 0; e_samp = '0; e_perr = '0; e_err = 0;
        end else begin
            bit slip;
            bit was_locked;
            slip = 0;
            was_locked = m_locked;
            e_valid = 0;
            qa.push_back(lane_in[0]); void'(qa.pop_front());
            qb.push_back(lane_in[1]); void'(qb.pop_front());
            qc.push_back(lane_in[2]); void'(qc.pop_front());
            if (m_cnt == 11) begin
                logic [8:0] w [4];
                logic [3:0] pe;
                for (int j = 0; j < 9; j++) begin
                    w[0][j] = qa[j]; w[1][j] = qb[j]; w[2][j] = qc[j];
                    w[3][j] = (j < 3) ? qa[9+j] : (j < 6) ? qb[6+j] : qc[3+j];
                end
                for (int c = 0; c < 4; c++) pe[c] = ~(^w[c]);
                if (was_locked) begin
                    e_valid = 1;
                    e_samp  = {w[3][7:0], w[2][7:0], w[1][7:0], w[0][7:0]};
                    e_perr  = pe;
                    if (pe != 0) begin
                        if (e_err < ERR_MAX) e_err++;
                        m_bad++;
                        if (m_bad == 3) begin m_locked = 0; m_bad = 0; m_good = 0; slip = 1; end
                    end else m_bad = 0;
                end else begin
                    if (pe == 0) begin
                        m_good++;
                        if (m_good == 4) begin m_locked = 1; m_good = 0; m_bad = 0; end
                    end else begin
                        m_good = 0; slip = 1;
                    end
                end
                m_cnt = slip ? 11 : 0;
            end else m_cnt++;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(locked === m_locked, "R4 R5 R6 locked", locked, m_locked);
            check(sample_valid === e_valid, "R7 R9 sample_valid", sample_valid, e_valid);
            check(samples === e_samp, "R2 samples", samples, e_samp);
            check(parity_error === e_perr, "R3 parity_error", parity_error, e_perr);
            check(err_frames === ERR_W'(e_err), "R8 err_frames", err_frames, e_err);
        end
    end

    // ---------------- stimulus ----------------
    task automatic send_bit(input logic [2:0] b);
        @(negedge clk);
        lane_in = b;
    endtask

    // Sends one frame; 'bad' flips parity per channel. With chk set, the
    // previous frame's output is checked in the cycle of this frame's slot 0.
    task automatic send_frame(input logic [31:0] s, input logic [3:0] bad,
                              input bit chk, input logic [31:0] prev, input logic [3:0] prev_err);
        logic [8:0] w [4];
        for (int c = 0; c < 4; c++) begin
            w[c] = {~(^s[8*c +: 8]), s[8*c +: 8]};
            if (bad[c]) w[c][8] = ~w[c][8];
        end
        for (int k = 0; k < 12; k++) begin
            if (k < 9) send_bit({w[2][k], w[1][k], w[0][k]});
            else       send_bit({w[3][k-3], w[3][k-6], w[3][k-9]});
            if (k == 0 && chk) begin
                check(sample_valid === 1'b1, "R9 strobe after slot 11", sample_valid, 1);
                check(samples === prev, "R2 slot mapping", samples, prev);
                check(parity_error === prev_err, "R3 flag per channel", parity_error, prev_err);
            end
        end
    endtask

    task automatic good_frames(input int n);
        for (int i = 0; i < n; i++) send_frame($urandom, 4'b0, 0, '0, '0);
    endtask

    initial begin
        logic [31:0] s1;
        logic [31:0] s2;
        repeat (3) @(negedge clk);
        check(locked === 0 && sample_valid === 0, "R1 reset flags", {locked, sample_valid}, 0);
        check(samples === 0 && parity_error === 0 && err_frames === 0, "R1 reset data",
              {samples, parity_error, err_frames}, 0);
        rst_n = 1'b1;

        // Start at an arbitrary phase: R4 hunting.
        for (int i = 0; i < 5; i++) send_bit(3'($urandom));
        good_frames(25);
        check(locked === 1, "R4 R5 lock acquired", locked, 1);

        // Known samples, exact strobe cycle and slot mapping (R2, R9).
        s1 = 32'hA5_3C_81_7E;
        s2 = 32'h00_FF_12_C9;
        send_frame(s1, 4'b0000, 0, '0, '0);
        send_frame(s2, 4'b0100, 1, s1, 4'b0000);
        send_frame($urandom, 4'b0000, 1, s2, 4'b0100);

        // Isolated and double failures keep lock (R6).
        good_frames(3);
        send_frame($urandom, 4'b1001, 0, '0, '0);
        send_frame($urandom, 4'b0010, 0, '0, '0);
        good_frames(2);
        check(locked === 1, "R6 two failures keep lock", locked, 1);

        // Three failures in a row drop lock (R6).
        for (int i = 0; i < 3; i++) send_frame($urandom, 4'b1000, 0, '0, '0);
        @(negedge clk);
        check(locked === 0, "R6 lock lost", locked, 0);
        check(err_frames === ERR_W'(6), "R8 count while locked", err_frames, 6);
        good_frames(30);
        check(locked === 1, "R5 relock", locked, 1);

        // One extra bit knocks the phase off; the block must recover (R4, R6).
        send_bit(3'b101);
        good_frames(40);
        check(locked === 1, "R4 relock after slip", locked, 1);

        // Drive the counter into saturation without losing lock (R8).
        for (int i = 0; i < 10; i++) begin
            send_frame($urandom, 4'b0001, 0, '0, '0);
            send_frame($urandom, 4'b0001, 0, '0, '0);
            good_frames(1);
        end
        good_frames(2);
        check(err_frames === ERR_W'(ERR_MAX), "R8 saturation", err_frames, ERR_MAX);
        check(locked === 1, "R6 alternating keeps lock", locked, 1);

        // Reset mid-stream clears everything (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(locked === 0 && err_frames === 0 && samples === 0, "R1 reset mid-run",
              {locked, err_frames, samples}, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule